// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the hardware half of a receive descriptor ring. Incoming frames arrive as a byte stream with a last-byte marker. The block cuts each frame into fixed-size buffers and writes the bytes into buffer memory one write at a time. When a buffer is finished, it writes back the status half of that buffer's 16-byte descriptor. Every write goes out on a single valid/ready memory write channel that carries a 64-bit data word and eight byte strobes.

Software programs the ring base, the ring length in bytes, the buffer pool base and the buffer size. It returns descriptors by moving the tail index. The block owns the head index. It raises three one-cycle events: end of frame written back, overrun, and free descriptors falling to a programmable fraction of the ring.

Back-pressure works as follows. The input stream is stalled with `in_ready` low only while a write is waiting in the output register that the memory side has not accepted. The input is also stalled for the one cycle in which a write-back is issued. Discarded bytes are always accepted at once. An output write holds its payload steady until `wr_ready` is seen high.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset the head index is 0, no memory write is pending, and all three event outputs are low.
- R2: When `rx_en` is low at the first byte of a frame, the whole frame is accepted and discarded. It produces no memory write, no event and no change of head.
- R3: Byte k of the buffer belonging to descriptor i is written to `buf_base + i*buffer_size + k`. Each such write carries the byte in every lane of `wr_data`, and its `wr_strb` has only bit `addr[2:0]` set.
- R4: The buffer size is 2048 bytes for `bsize_sel` code 0. Codes 1, 2 and 3 give 1024, 512 and 256 bytes. With `bsize_x16` set, codes 1 to 3 give 16384, 8192 and 4096 bytes.
- R5: After its buffer bytes, descriptor i gets a status write-back at `ring_base + 16*i + 8` with `wr_strb` 0xFF. Bits 15:0 hold the byte count of that buffer, and bits 32 (done) and 33 (end of frame) are status flags. The done flag is always 1. The end-of-frame flag is 1 only on the frame's last descriptor. All other bits are 0.
- R6: A frame longer than one buffer continues in the next descriptors. A frame whose size is exactly one buffer uses a single descriptor that is both full and marked end of frame.
- R7: Hardware writes only descriptors from head up to but not including `tail_idx`. Head advances by one per write-back and wraps to 0 after descriptor `ring_bytes/16 - 1`.
- R8: When a byte needs a descriptor while head equals tail, `ovr_evt` pulses for one cycle and the rest of the frame, that byte included, is discarded.
- R9: `rxt_evt` pulses for one cycle, in the cycle after the handshake of a write-back whose end-of-frame flag is set.
- R10: Free descriptors are counted as (tail - head) mod N. `low_evt` pulses for one cycle when that count falls from above to at or below N/2, N/4 or N/8, for `thr_sel` codes 0, 1 and 2. Code 3 never raises the event.
- R11: While `wr_valid` is high and `wr_ready` is low, the pending write's address, data and strobes stay unchanged and `wr_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable, sampled at frame start |
| bsize_sel | input | 2 | Buffer size code |
| bsize_x16 | input | 1 | Buffer size multiply-by-16 for codes 1..3 |
| thr_sel | input | 2 | Free-space threshold code |
| ring_base | input | AW | Byte address of descriptor 0 |
| buf_base | input | AW | Byte address of buffer 0 |
| ring_bytes | input | IDX_W+5 | Ring length in bytes (descriptors x 16) |
| tail_idx | input | IDX_W | Software tail index |
| head_idx | output | IDX_W | Hardware head index |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of frame |
| wr_valid | output | 1 | Memory write valid |
| wr_ready | input | 1 | Memory write ready |
| wr_addr | output | AW | Memory write byte address |
| wr_data | output | 64 | Memory write data |
| wr_strb | output | 8 | Memory write byte strobes |
| rxt_evt | output | 1 | End-of-frame write-back event |
| low_evt | output | 1 | Free descriptors low event |
| ovr_evt | output | 1 | Overrun event |

## Verification
The last byte of a frame can also be the byte that fills its buffer. Frame termination and buffer splitting then act on the same input beat, and both must be settled by one write-back. The bench sends a frame of exactly one buffer and another just over one buffer, and holds the memory side back at times. The scoreboard then expects exactly one write-back with full length and the end-of-frame flag for the first frame, and two write-backs for the second. It also checks that the next frame starts at offset 0 of the following descriptor.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_WB   = 2'd1,
    ST_DROP = 2'd2
  } rxr_state_e;

  localparam int DESC_SHIFT = 4;
  localparam int WB_OFFSET  = 8;

  // log2 of the buffer size for a size code and extension bit
  function automatic logic [3:0] bsize_shift(input logic [1:0] code, input logic x16);
    case (code)
      2'd0:    return 4'd11;
      2'd1:    return x16 ? 4'd14 : 4'd10;
      2'd2:    return x16 ? 4'd13 : 4'd9;
      default: return x16 ? 4'd12 : 4'd8;
    endcase
  endfunction

  // upper 8 bytes of a descriptor: len, checksum, status, errors, special
  function automatic logic [63:0] pack_wb(input logic [15:0] len, input logic eop);
    return {16'h0000, 8'h00, 6'b000000, eop, 1'b1, 16'h0000, len};
  endfunction

endpackage

// File: rtl/rxr_cfg.sv
module rxr_cfg #(
  parameter int IDX_W     = 12,
  parameter int MAX_SHIFT = 14,
  localparam int RLEN_W   = IDX_W + 5,
  localparam int CNT_W    = MAX_SHIFT + 1
) (
  input  logic [1:0]        bsize_sel,
  input  logic              bsize_x16,
  input  logic [1:0]        thr_sel,
  input  logic [RLEN_W-1:0] ring_bytes,
  output logic [3:0]        buf_shift,
  output logic [CNT_W-1:0]  buf_bytes,
  output logic [IDX_W:0]    n_desc,
  output logic [IDX_W:0]    thr_cnt,
  output logic              thr_on
);
  import rxr_pkg::*;

  always_comb begin
    buf_shift = bsize_shift(bsize_sel, bsize_x16);
    buf_bytes = CNT_W'(1) << buf_shift;
    n_desc    = (IDX_W+1)'(ring_bytes >> DESC_SHIFT);
    thr_on    = (thr_sel != 2'd3);
    case (thr_sel)
      2'd0:    thr_cnt = n_desc >> 1;
      2'd1:    thr_cnt = n_desc >> 2;
      2'd2:    thr_cnt = n_desc >> 3;
      default: thr_cnt = '0;
    endcase
  end

endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [IDX_W-1:0] tail_idx,
  input  logic [IDX_W:0]   n_desc,
  input  logic [IDX_W:0]   thr_cnt,
  input  logic             thr_on,
  output logic [IDX_W-1:0] head_idx,
  output logic             has_room,
  output logic             low_evt
);

  logic [IDX_W-1:0] head_q;
  logic [IDX_W-1:0] head_nxt;
  logic [IDX_W:0]   free_now;
  logic [IDX_W:0]   free_prev_q;

  always_comb begin
    if (({1'b0, head_q} + 1'b1) >= n_desc) head_nxt = '0;
    else                                   head_nxt = head_q + 1'b1;

    if (tail_idx >= head_q) free_now = {1'b0, tail_idx} - {1'b0, head_q};
    else                    free_now = n_desc - {1'b0, head_q} + {1'b0, tail_idx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q      <= '0;
      free_prev_q <= '0;
    end else begin
      free_prev_q <= free_now;
      if (adv) head_q <= head_nxt;
    end
  end

  assign head_idx = head_q;
  assign has_room = (head_q != tail_idx);
  assign low_evt  = thr_on && (free_now <= thr_cnt) && (free_prev_q > thr_cnt);

  AST_ADV_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (head_q != tail_idx)); // R7

endmodule

// File: rtl/rxr_wr_port.sv
module rxr_wr_port #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_addr,
  input  logic [63:0]   ld_data,
  input  logic [7:0]    ld_strb,
  input  logic          ld_wb,
  input  logic          ld_eop,
  output logic          free,
  input  logic          wr_ready,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [63:0]   wr_data,
  output logic [7:0]    wr_strb,
  output logic          rxt_evt
);

  logic          vld_q;
  logic [AW-1:0] addr_q;
  logic [63:0]   data_q;
  logic [7:0]    strb_q;
  logic          wb_q;
  logic          eop_q;
  logic          rxt_q;

  assign free = !vld_q || wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      strb_q <= '0;
      wb_q   <= 1'b0;
      eop_q  <= 1'b0;
      rxt_q  <= 1'b0;
    end else begin
      rxt_q <= vld_q && wr_ready && wb_q && eop_q;
      if (ld) begin
        vld_q  <= 1'b1;
        addr_q <= ld_addr;
        data_q <= ld_data;
        strb_q <= ld_strb;
        wb_q   <= ld_wb;
        eop_q  <= ld_eop;
      end else if (wr_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign wr_valid = vld_q;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;
  assign wr_strb  = strb_q;
  assign rxt_evt  = rxt_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !wr_ready) |=> (vld_q && $stable(addr_q) && $stable(data_q) && $stable(strb_q))); // R11
  AST_RXT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rxt_q |=> !rxt_q); // R9
  AST_WB_DONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && wb_q) |-> (data_q[32] && strb_q == 8'hFF)); // R5

endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer #(
  parameter int AW        = 32,
  parameter int IDX_W     = 12,
  parameter int MAX_SHIFT = 14,
  localparam int RLEN_W   = IDX_W + 5,
  localparam int CNT_W    = MAX_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [1:0]        bsize_sel,
  input  logic              bsize_x16,
  input  logic [1:0]        thr_sel,
  input  logic [AW-1:0]     ring_base,
  input  logic [AW-1:0]     buf_base,
  input  logic [RLEN_W-1:0] ring_bytes,
  input  logic [IDX_W-1:0]  tail_idx,
  output logic [IDX_W-1:0]  head_idx,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [63:0]       wr_data,
  output logic [7:0]        wr_strb,
  output logic              rxt_evt,
  output logic              low_evt,
  output logic              ovr_evt
);
  import rxr_pkg::*;

  logic [3:0]       buf_shift;
  logic [CNT_W-1:0] buf_bytes;
  logic [IDX_W:0]   n_desc;
  logic [IDX_W:0]   thr_cnt;
  logic             thr_on;
  logic             has_room;
  logic             out_free;

  rxr_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             in_frame_q;
  logic             eop_q;
  logic             ovr_q;

  logic             write_ok;
  logic             take;
  logic             buf_full;
  logic             ld;
  logic             adv;
  logic [AW-1:0]    byte_addr;
  logic [AW-1:0]    wb_addr;
  logic [7:0]       byte_strb;
  logic [AW-1:0]    ld_addr;
  logic [63:0]      ld_data;
  logic [7:0]       ld_strb;

  rxr_cfg #(.IDX_W(IDX_W), .MAX_SHIFT(MAX_SHIFT)) u_cfg (
    .bsize_sel (bsize_sel),
    .bsize_x16 (bsize_x16),
    .thr_sel   (thr_sel),
    .ring_bytes(ring_bytes),
    .buf_shift (buf_shift),
    .buf_bytes (buf_bytes),
    .n_desc    (n_desc),
    .thr_cnt   (thr_cnt),
    .thr_on    (thr_on)
  );

  rxr_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .tail_idx(tail_idx),
    .n_desc  (n_desc),
    .thr_cnt (thr_cnt),
    .thr_on  (thr_on),
    .head_idx(head_idx),
    .has_room(has_room),
    .low_evt (low_evt)
  );

  // buffer and descriptor addresses for the current head
  assign byte_addr = buf_base + (AW'(head_idx) << buf_shift) + AW'(cnt_q);
  assign wb_addr   = ring_base + (AW'(head_idx) << DESC_SHIFT) + AW'(WB_OFFSET);

  for (genvar l = 0; l < 8; l++) begin : g_lane
    assign byte_strb[l] = (byte_addr[2:0] == 3'(l));
  end

  always_comb begin
    write_ok = (in_frame_q || rx_en) && has_room;
    cnt_inc  = cnt_q + 1'b1;
    buf_full = (cnt_inc == buf_bytes);
    case (state_q)
      ST_DATA: in_ready = write_ok ? out_free : 1'b1;
      ST_WB:   in_ready = 1'b0;
      default: in_ready = 1'b1;
    endcase
    take = in_valid && in_ready;
    adv  = (state_q == ST_WB) && out_free;
    ld   = adv || ((state_q == ST_DATA) && take && write_ok);
    if (state_q == ST_WB) begin
      ld_addr = wb_addr;
      ld_data = pack_wb(16'(cnt_q), eop_q);
      ld_strb = 8'hFF;
    end else begin
      ld_addr = byte_addr;
      ld_data = {8{in_data}};
      ld_strb = byte_strb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_DATA;
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      eop_q      <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      ovr_q <= 1'b0;
      case (state_q)
        ST_DATA: begin
          if (take) begin
            if (write_ok) begin
              cnt_q      <= cnt_inc;
              in_frame_q <= !in_last;
              if (in_last || buf_full) begin
                eop_q   <= in_last;
                state_q <= ST_WB;
              end
            end else begin
              ovr_q      <= in_frame_q || rx_en;
              in_frame_q <= 1'b0;
              if (!in_last) state_q <= ST_DROP;
            end
          end
        end
        ST_WB: begin
          if (out_free) begin
            cnt_q   <= '0;
            state_q <= ST_DATA;
          end
        end
        default: begin
          if (take && in_last) state_q <= ST_DATA;
        end
      endcase
    end
  end

  assign ovr_evt = ovr_q;

  rxr_wr_port #(.AW(AW)) u_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (ld),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .ld_strb (ld_strb),
    .ld_wb   (state_q == ST_WB),
    .ld_eop  (eop_q),
    .free    (out_free),
    .wr_ready(wr_ready),
    .wr_valid(wr_valid),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_strb (wr_strb),
    .rxt_evt (rxt_evt)
  );

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WB) |-> (cnt_q != '0 && cnt_q <= buf_bytes)); // R6
  AST_DROP_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DROP) |=> !(wr_valid && !$past(wr_valid))); // R8

endmodule

// File: tb/sim_rxr_ring_writer.sv
module sim_rxr_ring_writer;

  localparam logic [31:0] RING_BASE = 32'h0000_1000;
  localparam logic [31:0] BUF_BASE  = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic [1:0]  bsize_sel = 2'd3;
  logic        bsize_x16 = 1'b0;
  logic [1:0]  thr_sel = 2'd1;
  logic [31:0] ring_base = RING_BASE;
  logic [31:0] buf_base = BUF_BASE;
  logic [16:0] ring_bytes = 17'd128;
  logic [11:0] tail_idx = '0;
  logic [11:0] head_idx;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [31:0] wr_addr;
  logic [63:0] wr_data;
  logic [7:0]  wr_strb;
  logic        rxt_evt, low_evt, ovr_evt;

  rxr_ring_writer u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bsize_sel(bsize_sel), .bsize_x16(bsize_x16),
    .thr_sel(thr_sel), .ring_base(ring_base), .buf_base(buf_base), .ring_bytes(ring_bytes),
    .tail_idx(tail_idx), .head_idx(head_idx), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb), .rxt_evt(rxt_evt),
    .low_evt(low_evt), .ovr_evt(ovr_evt)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [103:0] exp_q[$];

  // reference model state
  int m_n = 8, m_head = 0, m_tail = 0, m_cnt = 0, m_bsz = 256, m_thr = 2;
  bit m_thr_on = 1, m_en = 0, m_inframe = 0, m_drop = 0;
  int exp_rxt = 0, exp_low = 0, exp_ovr = 0;
  int obs_rxt = 0, obs_low = 0, obs_ovr = 0;
  bit bp_on = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [103:0] act, input logic [103:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int free_cnt();
    return (m_tail - m_head + m_n) % m_n;
  endfunction

  task automatic model_byte(input logic [7:0] b, input bit last);
    logic [31:0] a;
    int old_free, new_free;
    if (m_drop) begin
      if (last) m_drop = 0;
      return;
    end
    if (!m_inframe && !m_en) begin      // R2
      if (!last) m_drop = 1;
      return;
    end
    if (m_head == m_tail) begin         // R8
      exp_ovr++;
      m_inframe = 0;
      if (!last) m_drop = 1;
      return;
    end
    a = BUF_BASE + 32'(m_head * m_bsz + m_cnt);
    exp_q.push_back({a, {8{b}}, 8'(8'd1 << a[2:0])});
    m_cnt++;
    m_inframe = !last;
    if (last || m_cnt == m_bsz) begin
      exp_q.push_back({RING_BASE + 32'(m_head * 16 + 8),
                       {16'h0, 8'h0, 6'h0, last, 1'b1, 16'h0, 16'(m_cnt)}, 8'hFF});
      if (last) exp_rxt++;
      old_free = free_cnt();
      m_head = (m_head + 1) % m_n;
      new_free = free_cnt();
      if (m_thr_on && old_free > m_thr && new_free <= m_thr) exp_low++;
      m_cnt = 0;
    end
  endtask

  task automatic drive_byte(input logic [7:0] b, input bit last);
    in_valid = 1'b1;
    in_data  = b;
    in_last  = last;
    forever begin
      #3;
      if (in_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic send_frame(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      model_byte(8'(seed + i), i == len - 1);
      drive_byte(8'(seed + i), i == len - 1);
    end
  endtask

  task automatic wait_idle();
    int k = 0;
    while ((exp_q.size() != 0 || wr_valid) && k < 5000) begin
      @(negedge clk);
      k++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_state(input string tag);
    #3;
    chk(head_idx == 12'(m_head), "R7", {tag, " head"}, 104'(head_idx), 104'(m_head));
    chk(obs_rxt == exp_rxt, "R9", {tag, " rxt count"}, 104'(obs_rxt), 104'(exp_rxt));
    chk(obs_low == exp_low, "R10", {tag, " low count"}, 104'(obs_low), 104'(exp_low));
    chk(obs_ovr == exp_ovr, "R8", {tag, " ovr count"}, 104'(obs_ovr), 104'(exp_ovr));
    chk(exp_q.size() == 0, "R3", {tag, " missing writes"}, 104'(exp_q.size()), 104'(0));
  endtask

  // back-pressure pattern on the memory side
  always @(negedge clk) begin
    cyc++;
    wr_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
  end

  // monitor / scoreboard
  initial begin
    bit hold_pend = 0;
    logic [103:0] held = '0;
    logic [103:0] act;
    logic [103:0] e;
    forever begin
      @(negedge clk);
      #3;
      if (rst_n) begin
        act = {wr_addr, wr_data, wr_strb};
        if (rxt_evt) obs_rxt++;
        if (low_evt) obs_low++;
        if (ovr_evt) obs_ovr++;
        if (hold_pend)
          chk(wr_valid && act == held, "R11", "stalled write changed", act, held);
        hold_pend = wr_valid && !wr_ready;
        held = act;
        if (wr_valid && wr_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3", "unexpected write", act, '0);
          end else begin
            e = exp_q.pop_front();
            chk(act == e, "R3 R5 R6", "write mismatch", act, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    // R1: reset state
    chk(!wr_valid, "R1", "wr_valid in reset", 104'(wr_valid), 0);
    chk(head_idx == 0, "R1", "head in reset", 104'(head_idx), 0);
    chk(!rxt_evt && !low_evt && !ovr_evt, "R1", "events in reset",
        104'({rxt_evt, low_evt, ovr_evt}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: disabled receiver discards the frame
    send_frame(5, 8'h10);
    wait_idle();
    chk_state("R2 disabled");

    tail_idx = 12'd7; m_tail = 7;
    rx_en = 1'b1; m_en = 1;
    repeat (2) @(negedge clk);

    send_frame(10, 8'h20);             // R3 R5 single descriptor
    wait_idle();
    chk_state("R3 short frame");

    bp_on = 1;                         // R6 R11 split under back-pressure
    send_frame(300, 8'h40);
    wait_idle();
    bp_on = 0;
    chk_state("R6 split frame");

    send_frame(256, 8'h80);            // R6 full buffer and end of frame together
    wait_idle();
    chk_state("R6 exact buffer");

    send_frame(20, 8'h33);             // R10 free falls 3 -> 2
    wait_idle();
    chk_state("R10 threshold");

    send_frame(20, 8'h44);
    wait_idle();
    chk_state("R10 below threshold");

    send_frame(600, 8'h55);            // R8 mid-frame overrun
    wait_idle();
    chk_state("R8 overrun");

    tail_idx = 12'd3; m_tail = 3;      // R7 wrap
    repeat (2) @(negedge clk);
    send_frame(40, 8'h66);
    wait_idle();
    chk_state("R7 wrap");

    thr_sel = 2'd3; m_thr_on = 0;      // R10 reserved code, R4 4096 buffers
    bsize_x16 = 1'b1; m_bsz = 4096;
    repeat (2) @(negedge clk);
    send_frame(10, 8'h70);
    wait_idle();
    chk_state("R4 R10 reserved");
    send_frame(10, 8'h90);
    wait_idle();
    chk_state("R4 ext size");

    send_frame(10, 8'hA0);
    wait_idle();
    send_frame(5, 8'hB0);              // R8 overrun at frame start
    wait_idle();
    chk_state("R8 start overrun");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule